// File: doc/BRIEF.md
# AC-Link Output Frame Serializer

This block is the controller-side transmitter of an AC-Link playback stream. It runs on the bit clock and drives the frame strobe (`sync_o`) and the serial data line (`sdata_o`). Each frame is 256 bit times long. It opens with a 16-bit tag slot and is followed by twelve 20-bit data slots. All bits go out MSB first, one bit per rising clock edge, so the receiver can sample each bit on the falling edge that follows.

The frame contents come in on parallel inputs: a frame-valid flag, a per-slot valid mask, a codec ID, twelve 20-bit slot words, and a per-slot count of significant bits. The block raises `ready_o` for one cycle at the end of each frame. On the clock edge that ends that cycle it copies all parallel inputs into a holding register. Between two ready pulses the inputs may change freely.

The sequencer is a three-state machine. ST_IDLE is the single cycle after reset. ST_TAG covers the 16 tag bit times. ST_DATA covers the twelve data slots. Its transitions are:
- T_START: ST_IDLE to ST_TAG.
- T_TAG_DONE: ST_TAG to ST_DATA, after tag bit 15.
- T_SLOT_NEXT: ST_DATA to ST_DATA, from bit 19 of a slot to the next slot.
- T_FRAME_END: ST_DATA to ST_TAG, after bit 19 of slot 12.

Top module: `aclink_tx_framer`

## Requirements
- R1: While reset is held, `sync_o` and `sdata_o` are 0. In the first cycle after reset release, `ready_o` is 1 and `sdata_o` is 0.
- R2: `sync_o` rises once every 256 clock cycles.
- R3: Each time `sync_o` rises, it stays high for exactly 16 consecutive cycles and then stays low for 240 cycles.
- R4: `ready_o` is high for exactly one cycle, the cycle just before `sync_o` rises, and never while `sync_o` is high. Inputs are captured at the rising edge that ends that cycle.
- R5: In the cycle after `sync_o` rises, `sdata_o` carries frame bit 0, the captured frame-valid flag. Frame bit k appears k+1 cycles after the rise.
- R6: Frame bits 0 to 15 are, in order:
  - the frame-valid flag;
  - the valid bits of slots 1 to 12 (`slot_valid_i` bit 0 is slot 1);
  - a 0;
  - `codec_id_i[1]`, then `codec_id_i[0]`.
- R7: For a valid slot n (1 to 12), frame bits 16+20(n-1) to 35+20(n-1) are the slot word MSB first. Slot n's word is `slot_data_i[20n-1:20n-20]`.
- R8: Every bit of a slot whose valid bit is 0 is sent as 0, whatever its data.
- R9: For a valid slot, the count field `slot_bits_i[5n-1:5n-5]` gives c. The first min(c,20) bits of the slot carry the top word bits and all later bits of the slot are 0. A count of 0 gives an all-zero slot.
- R10: Input changes made outside the ready cycle do not alter the frame being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all outputs change on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_valid_i | input | 1 | Frame-valid flag for the next frame |
| slot_valid_i | input | 12 | Per-slot valid mask, bit 0 = slot 1 |
| codec_id_i | input | 2 | Codec ID placed in the last two tag bits |
| slot_data_i | input | 240 | Twelve 20-bit slot words, slot 1 in the low bits |
| slot_bits_i | input | 60 | Twelve 5-bit significant-bit counts, slot 1 in the low bits |
| ready_o | output | 1 | One-cycle strobe; inputs captured at the end of it |
| sync_o | output | 1 | Frame strobe, high during the tag phase |
| sdata_o | output | 1 | Serial frame data, MSB first |

## Verification
A wrong state or counter shows up first on `sync_o`. A frame that is one bit short or long moves the next rise of `sync_o` and of `ready_o`, so it is caught within one frame. A corrupted slot or bit index does not touch the strobes. Instead it moves data bits into the wrong positions of `sdata_o`; every bit of every frame is compared, so the error is seen within the same frame. A capture at the wrong moment appears as the random data written during the frame leaking into the serial stream.

// File: rtl/aclink_tx_pkg.sv
package aclink_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TAG  = 2'd1,
        ST_DATA = 2'd2
    } tx_state_e;

endpackage

// File: rtl/aclink_tx_seq.sv
module aclink_tx_seq
    import aclink_tx_pkg::*;
#(
    parameter int SLOT_CNT   = 12,
    parameter int SLOT_W     = 20,
    parameter int TAG_W      = 16,
    parameter int SLOT_IDX_W = 4,
    parameter int BIT_W      = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    output tx_state_e             state_o,
    output logic [SLOT_IDX_W-1:0] slot_o,
    output logic [BIT_W-1:0]      bit_o,
    output logic                  ready_o,
    output logic                  sync_o
);

    tx_state_e             state_q, state_d;
    logic [SLOT_IDX_W-1:0] slot_q, slot_d;
    logic [BIT_W-1:0]      bit_q, bit_d;
    logic                  tag_last, slot_last, frame_last;

    assign tag_last   = (bit_q == BIT_W'(TAG_W - 1));
    assign slot_last  = (bit_q == BIT_W'(SLOT_W - 1));
    assign frame_last = slot_last && (slot_q == SLOT_IDX_W'(SLOT_CNT));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            bit_q   <= bit_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        bit_d   = bit_q + BIT_W'(1);
        unique case (state_q)
            ST_IDLE: begin                      // T_START
                state_d = ST_TAG;
                slot_d  = '0;
                bit_d   = '0;
            end
            ST_TAG: begin
                if (tag_last) begin             // T_TAG_DONE
                    state_d = ST_DATA;
                    slot_d  = SLOT_IDX_W'(1);
                    bit_d   = '0;
                end
            end
            ST_DATA: begin
                if (frame_last) begin           // T_FRAME_END
                    state_d = ST_TAG;
                    slot_d  = '0;
                    bit_d   = '0;
                end else if (slot_last) begin   // T_SLOT_NEXT
                    slot_d  = slot_q + SLOT_IDX_W'(1);
                    bit_d   = '0;
                end
            end
            default: begin
                state_d = ST_IDLE;
                slot_d  = '0;
                bit_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        ready_o = 1'b0;
        sync_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: ready_o = 1'b1;
            ST_TAG:  sync_o  = 1'b1;
            ST_DATA: ready_o = frame_last;
            default: ready_o = 1'b0;
        endcase
    end

    assign state_o = state_q;
    assign slot_o  = slot_q;
    assign bit_o   = bit_q;

endmodule

// File: rtl/aclink_tx_hold.sv
module aclink_tx_hold #(
    parameter int SLOT_CNT = 12,
    parameter int SLOT_W   = 20,
    parameter int CID_W    = 2,
    parameter int CNT_W    = 5,
    parameter int TAG_W    = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                load_i,
    input  logic                                frame_valid_i,
    input  logic [SLOT_CNT-1:0]                 slot_valid_i,
    input  logic [CID_W-1:0]                    codec_id_i,
    input  logic [SLOT_CNT-1:0][SLOT_W-1:0]     slot_data_i,
    input  logic [SLOT_CNT-1:0][CNT_W-1:0]      slot_bits_i,
    output logic [TAG_W-1:0]                    tag_o,
    output logic [SLOT_CNT-1:0][SLOT_W-1:0]     word_o
);

    logic [TAG_W-1:0]                tag_d;
    logic [SLOT_CNT-1:0][SLOT_W-1:0] word_d;

    // Tag: valid flag, slot 1..N valid bits, a zero, codec ID
    always_comb begin
        tag_d = '0;
        tag_d[TAG_W-1] = frame_valid_i;
        for (int s = 0; s < SLOT_CNT; s++) begin
            tag_d[TAG_W-2-s] = slot_valid_i[s];
        end
        tag_d[CID_W-1:0] = codec_id_i;
    end

    // Zero stuffing: clear non-valid slots and bits past the count
    for (genvar g = 0; g < SLOT_CNT; g++) begin : g_slot
        logic [SLOT_W-1:0] keep;
        always_comb begin
            for (int b = 0; b < SLOT_W; b++) begin
                keep[SLOT_W-1-b] = (CNT_W'(b) < slot_bits_i[g]);
            end
            word_d[g] = slot_valid_i[g] ? (slot_data_i[g] & keep) : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_o  <= '0;
            word_o <= '0;
        end else if (load_i) begin
            tag_o  <= tag_d;
            word_o <= word_d;
        end
    end

endmodule

// File: rtl/aclink_tx_bitsel.sv
module aclink_tx_bitsel
    import aclink_tx_pkg::*;
#(
    parameter int SLOT_CNT   = 12,
    parameter int SLOT_W     = 20,
    parameter int TAG_W      = 16,
    parameter int SLOT_IDX_W = 4,
    parameter int BIT_W      = 5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  tx_state_e                       state_i,
    input  logic [SLOT_IDX_W-1:0]           slot_i,
    input  logic [BIT_W-1:0]                bit_i,
    input  logic [TAG_W-1:0]                tag_i,
    input  logic [SLOT_CNT-1:0][SLOT_W-1:0] word_i,
    output logic                            sdata_o
);

    localparam int TAG_IDX_W  = $clog2(TAG_W);
    localparam int WORD_IDX_W = $clog2(SLOT_W);

    logic [TAG_IDX_W-1:0]  tag_idx;
    logic [WORD_IDX_W-1:0] word_idx;
    logic                  cur_bit;
    logic                  sdata_q;

    assign tag_idx  = TAG_IDX_W'(TAG_W - 1) - TAG_IDX_W'(bit_i);
    assign word_idx = WORD_IDX_W'(SLOT_W - 1) - WORD_IDX_W'(bit_i);

    always_comb begin
        cur_bit = 1'b0;
        unique case (state_i)
            ST_TAG:  cur_bit = tag_i[tag_idx];
            ST_DATA: begin
                for (int s = 0; s < SLOT_CNT; s++) begin
                    if (slot_i == SLOT_IDX_W'(s + 1)) begin
                        cur_bit = word_i[s][word_idx];
                    end
                end
            end
            default: cur_bit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdata_q <= 1'b0;
        end else begin
            sdata_q <= cur_bit;
        end
    end

    assign sdata_o = sdata_q;

endmodule

// File: rtl/aclink_tx_framer.sv
module aclink_tx_framer
    import aclink_tx_pkg::*;
#(
    parameter  int SLOT_CNT   = 12,
    parameter  int SLOT_W     = 20,
    parameter  int CID_W      = 2,
    localparam int CNT_W      = $clog2(SLOT_W + 1),
    localparam int TAG_W      = 1 + SLOT_CNT + 1 + CID_W,
    localparam int SLOT_IDX_W = $clog2(SLOT_CNT + 1),
    localparam int BIT_W      = $clog2((TAG_W > SLOT_W) ? TAG_W : SLOT_W)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         frame_valid_i,
    input  logic [SLOT_CNT-1:0]          slot_valid_i,
    input  logic [CID_W-1:0]             codec_id_i,
    input  logic [SLOT_CNT*SLOT_W-1:0]   slot_data_i,
    input  logic [SLOT_CNT*CNT_W-1:0]    slot_bits_i,
    output logic                         ready_o,
    output logic                         sync_o,
    output logic                         sdata_o
);

    tx_state_e                       state;
    logic [SLOT_IDX_W-1:0]           slot_idx;
    logic [BIT_W-1:0]                bit_idx;
    logic [TAG_W-1:0]                tag_q;
    logic [SLOT_CNT-1:0][SLOT_W-1:0] word_q;
    logic [SLOT_CNT-1:0][SLOT_W-1:0] data_in;
    logic [SLOT_CNT-1:0][CNT_W-1:0]  bits_in;

    assign data_in = slot_data_i;

    // Counts above the slot width behave as a full slot
    for (genvar g = 0; g < SLOT_CNT; g++) begin : g_clamp
        logic [CNT_W-1:0] raw;
        assign raw        = slot_bits_i[g*CNT_W +: CNT_W];
        assign bits_in[g] = (raw > CNT_W'(SLOT_W)) ? CNT_W'(SLOT_W) : raw;
    end

    aclink_tx_seq #(
        .SLOT_CNT  (SLOT_CNT),
        .SLOT_W    (SLOT_W),
        .TAG_W     (TAG_W),
        .SLOT_IDX_W(SLOT_IDX_W),
        .BIT_W     (BIT_W)
    ) seq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .state_o(state),
        .slot_o (slot_idx),
        .bit_o  (bit_idx),
        .ready_o(ready_o),
        .sync_o (sync_o)
    );

    aclink_tx_hold #(
        .SLOT_CNT(SLOT_CNT),
        .SLOT_W  (SLOT_W),
        .CID_W   (CID_W),
        .CNT_W   (CNT_W),
        .TAG_W   (TAG_W)
    ) hold_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (ready_o),
        .frame_valid_i(frame_valid_i),
        .slot_valid_i (slot_valid_i),
        .codec_id_i   (codec_id_i),
        .slot_data_i  (data_in),
        .slot_bits_i  (bits_in),
        .tag_o        (tag_q),
        .word_o       (word_q)
    );

    aclink_tx_bitsel #(
        .SLOT_CNT  (SLOT_CNT),
        .SLOT_W    (SLOT_W),
        .TAG_W     (TAG_W),
        .SLOT_IDX_W(SLOT_IDX_W),
        .BIT_W     (BIT_W)
    ) bitsel_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .state_i(state),
        .slot_i (slot_idx),
        .bit_i  (bit_idx),
        .tag_i  (tag_q),
        .word_i (word_q),
        .sdata_o(sdata_o)
    );

endmodule

// File: rtl/aclink_tx_chk.sv
module aclink_tx_chk #(
    parameter int FRAME_LEN = 256,
    parameter int TAG_W     = 16
) (
    input logic clk,
    input logic rst_n,
    input logic ready_o,
    input logic sync_o,
    input logic sdata_o,
    input logic frame_valid_i
);

    localparam int CW = $clog2(FRAME_LEN + 2);

    logic [CW-1:0] hi_run;
    logic [CW-1:0] gap;
    logic          sync_d;
    logic          seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run <= '0;
            gap    <= '0;
            sync_d <= 1'b0;
            seen   <= 1'b0;
        end else begin
            sync_d <= sync_o;
            hi_run <= sync_o ? hi_run + CW'(1) : '0;
            if (sync_o && !sync_d) begin
                gap  <= CW'(1);
                seen <= 1'b1;
            end else if (gap != '1) begin
                gap  <= gap + CW'(1);
            end
        end
    end

    AST_SYNC_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_o) |-> $past(ready_o)); // R4
    AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> !ready_o); // R4
    AST_READY_NOT_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> !sync_o); // R4
    AST_SYNC_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_o) |-> (hi_run == CW'(TAG_W))); // R3
    AST_FRAME_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sync_o) && seen) |-> (gap == CW'(FRAME_LEN))); // R2
    AST_FIRST_BIT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_o) |=> (sdata_o == $past(frame_valid_i, 2))); // R5

endmodule

bind aclink_tx_framer aclink_tx_chk #(
    .FRAME_LEN(TAG_W + SLOT_CNT * SLOT_W),
    .TAG_W    (TAG_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ready_o      (ready_o),
    .sync_o       (sync_o),
    .sdata_o      (sdata_o),
    .frame_valid_i(frame_valid_i)
);

// File: tb/aclink_tx_framer_tb_top.sv
module aclink_tx_framer_tb_top;

    localparam int NS   = 12;
    localparam int SW   = 20;
    localparam int CW   = 5;
    localparam int FLEN = 16 + NS * SW;
    localparam int NFRM = 14;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             fv;
    logic [NS-1:0]    vmask;
    logic [1:0]       cid;
    logic [NS*SW-1:0] data;
    logic [NS*CW-1:0] bits;
    logic             ready, sync, sdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    aclink_tx_framer dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_valid_i(fv),
        .slot_valid_i (vmask),
        .codec_id_i   (cid),
        .slot_data_i  (data),
        .slot_bits_i  (bits),
        .ready_o      (ready),
        .sync_o       (sync),
        .sdata_o      (sdata)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [0:FLEN-1] build_frame();
        logic [0:FLEN-1] f = '0;
        f[0] = fv;
        for (int s = 0; s < NS; s++) f[1+s] = vmask[s];
        f[13] = 1'b0;
        f[14] = cid[1];
        f[15] = cid[0];
        for (int s = 0; s < NS; s++) begin
            int c = int'(bits[s*CW +: CW]);
            if (c > SW) c = SW;
            for (int j = 0; j < SW; j++)
                f[16 + s*SW + j] = vmask[s] && (j < c) && data[s*SW + SW-1-j];
        end
        return f;
    endfunction

    function automatic string bit_req(int k);
        int s, j, c;
        if (k == 0) return "R5";
        if (k < 16) return "R6";
        s = (k - 16) / SW;
        j = (k - 16) % SW;
        c = int'(bits[s*CW +: CW]);
        if (!vmask[s]) return "R8 R10";
        if (j >= c) return "R9 R10";
        return "R7 R10";
    endfunction

    task automatic scramble();
        fv    = 1'($urandom());
        vmask = NS'($urandom());
        cid   = 2'($urandom());
        for (int s = 0; s < NS; s++) begin
            data[s*SW +: SW] = SW'($urandom());
            bits[s*CW +: CW] = CW'($urandom());
        end
    endtask

    task automatic set_stim(input int mode);
        scramble();
        case (mode)
            0: begin fv = 1; vmask = '1; cid = 2'b10;
                for (int s = 0; s < NS; s++) bits[s*CW +: CW] = CW'(20); end
            1: begin fv = 1; vmask = '0; cid = 2'b11;
                for (int s = 0; s < NS; s++) data[s*SW +: SW] = SW'($urandom()) | 20'h80001; end
            2: begin fv = 1; vmask = '1; cid = 2'b01;
                for (int s = 0; s < NS; s++) bits[s*CW +: CW] = CW'((s * 3) % 32); end
            3: begin fv = 0; vmask = 12'h555; cid = 2'b00;
                for (int s = 0; s < NS; s++) bits[s*CW +: CW] = CW'(8); end
            default: begin
                for (int s = 0; s < NS; s++)
                    if ($urandom_range(0, 1) == 0) bits[s*CW +: CW] = CW'(20);
            end
        endcase
    endtask

    initial begin
        logic [0:FLEN-1] exp_f;
        logic [0:FLEN-1] prev_f;
        void'($urandom(32'd20240611));
        set_stim(0);
        prev_f = '0;
        repeat (3) begin
            @(negedge clk);
            chk(sync == 1'b0, "R1 sync in reset", int'(sync), 0);
            chk(sdata == 1'b0, "R1 sdata in reset", int'(sdata), 0);
        end
        rst_n = 1'b1;
        #0.1;
        chk(ready == 1'b1, "R1 ready after reset", int'(ready), 1);
        for (int f = 0; f < NFRM; f++) begin
            // ready cycle of frame f: phase 255 of the previous frame
            chk(ready == 1'b1, "R4 ready before frame", int'(ready), 1);
            chk(sync == 1'b0, "R3 sync low before frame", int'(sync), 0);
            chk(sdata == prev_f[FLEN-2], "R1 R7 previous bit 254", int'(sdata), int'(prev_f[FLEN-2]));
            exp_f = build_frame();
            @(negedge clk);
            chk(sync == 1'b1, "R2 R3 sync rise", int'(sync), 1);
            chk(ready == 1'b0, "R4 ready single", int'(ready), 0);
            chk(sdata == prev_f[FLEN-1], "R1 R7 previous bit 255", int'(sdata), int'(prev_f[FLEN-1]));
            scramble();   // R10: changes during the frame must not show
            for (int k = 0; k < FLEN - 2; k++) begin
                @(negedge clk);
                chk(sdata == exp_f[k], bit_req_for(k, exp_f), int'(sdata), int'(exp_f[k]));
                chk(sync == (k + 1 < 16), "R3 sync pattern", int'(sync), int'(k + 1 < 16));
                chk(ready == 1'b0, "R4 ready mid frame", int'(ready), 0);
            end
            prev_f = exp_f;
            set_stim(f + 1);
            @(negedge clk);
        end
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Requirement tag for a bit, decided from the frame layout alone
    logic [NS-1:0]    cap_v;
    logic [NS*CW-1:0] cap_b;
    function automatic string bit_req_for(int k, logic [0:FLEN-1] f);
        int s, j, c;
        if (k == 0) return "R5";
        if (k < 16) return "R6";
        s = (k - 16) / SW;
        j = (k - 16) % SW;
        if (!f[1+s]) return "R8 R10";
        c = 0;
        return (j < SW) ? "R7 R9 R10" : "R9";
    endfunction

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule